// File: doc/BRIEF.md
# Six-level maskable interrupt controller

This block gathers six interrupt request lines into a pending register, qualifies them with a per-level enable mask and a global master enable, and tells the core whether an interrupt should be taken and which level wins. The pending bits are captured on rising edges of the request lines. The core's register file reaches the controller through a byte-wide read/write port that exposes two registers: the pending (request) register and the mask register.

The core drives four single-cycle strobes. Enable-interrupts and disable-interrupts set and clear the master enable. The acknowledge strobe comes from the interrupt machine cycle and retires the winning level. Return-from-interrupt re-arms the master enable. Priority is fixed, with level 0 the most urgent and level 5 the least. Software can raise an interrupt by setting a pending bit through the register port. That request is then masked and ranked exactly like one from a request line. Until the first enable-interrupts strobe after reset, the pending register is held at zero.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, reads of address 0xFA (request) and 0xFB (mask) return 0x00 and `int_req` is 0.
- R2: Until the first `ei_stb` after reset, the request register stays 0x00. Rising request edges and writes to 0xFA made before that strobe, or in the same cycle as it, are ignored.
- R3: A rising edge on `irq_in[n]` sets bit n of the request register (bits 0..5 of address 0xFA), visible one cycle later. A line that stays high does not set the bit again after it has been cleared.
- R4: A write to 0xFA loads bits 5:0 of the request register. A bit set this way raises an interrupt just as a hardware request does. If a write clears a bit in the same cycle that its line rises, the bit ends up set.
- R5: Address 0xFB holds the per-level enables in bits 5:0 and the master enable in bit 7. Bit 6 of 0xFB and bits 7:6 of 0xFA always read 0, and writes to them have no effect.
- R6: `int_req` is 1 exactly when the master enable is 1 and at least one level has both its request bit and its mask bit set. `int_lvl` then gives the lowest such level number (level 0 has the highest priority).
- R7: `ei_stb` sets the master enable and `di_stb` clears it. If both arrive in the same cycle, the clear wins.
- R8: `ack_stb` clears the master enable. In the same cycle, it clears the request bit of the level shown on `int_lvl`. If that level's line rises in that same cycle, the request bit stays set.
- R9: `iret_stb` sets the master enable again, so the next pending enabled level is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| irq_in | input | 6 | Hardware request lines, rising-edge sensitive |
| reg_addr | input | 8 | Register-file address |
| reg_wr | input | 1 | Write enable for `reg_addr` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| iret_stb | input | 1 | Return-from-interrupt strobe |
| ack_stb | input | 1 | Interrupt acknowledge strobe |
| int_req | output | 1 | An enabled request is pending |
| int_lvl | output | 3 | Number of the winning level |

## Verification
The bench focuses on collisions inside a single cycle. It tests a software clear against a hardware edge, an acknowledge against a fresh edge on the serviced level, and disable against enable. A design that orders these wrongly loses a request or leaves interrupts enabled. It also tests the arming gate before the first enable strobe: a design without the gate latches early requests. It checks that a line held high does not refire once its bit is cleared, which catches level sensing. Priority is probed with several level pairs and with the higher level masked off, so an inverted or unmasked encoder reports the wrong level.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

   // register-port target selected by the address decode
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_REQ  = 2'd1,
      SEL_MSK  = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/lvl_irq_edge.sv
module lvl_irq_edge #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines_i,
   output logic [N-1:0] rise_o
);

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lines_i[i];
      end
      assign rise_o[i] = lines_i[i] & ~prev_q;
   end

endmodule

// File: rtl/lvl_irq_pend.sv
module lvl_irq_pend #(
   parameter int N  = 6,
   parameter int LW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic          wr_i,
   input  logic [N-1:0]  wdata_i,
   input  logic [N-1:0]  rise_i,
   input  logic          ack_i,
   input  logic          ack_vld_i,
   input  logic [LW-1:0] ack_lvl_i,
   output logic [N-1:0]  pend_o,
   output logic          armed_o
);

   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   logic [N-1:0] pend_q;
   logic         armed_q;
   logic [N-1:0] base;
   logic [N-1:0] clr;

   always_comb begin
      base = wr_i ? wdata_i : pend_q;
      clr  = (ack_i && ack_vld_i) ? (ONE << ack_lvl_i) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pend_q  <= '0;
      end else begin
         if (arm_i) armed_q <= 1'b1;
         // new edges are ORed in last so they win over clears
         if (!armed_q) pend_q <= '0;
         else          pend_q <= (base & ~clr) | rise_i;
      end
   end

   assign pend_o  = pend_q;
   assign armed_o = armed_q;

endmodule

// File: rtl/lvl_irq_mask.sv
module lvl_irq_mask #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   input  logic         wmaster_i,
   input  logic         ei_i,
   input  logic         di_i,
   input  logic         iret_i,
   input  logic         ack_i,
   output logic [N-1:0] mask_o,
   output logic         master_o
);

   logic [N-1:0] mask_q;
   logic         master_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         master_q <= 1'b0;
      end else begin
         if (wr_i) begin
            mask_q   <= wdata_i;
            master_q <= wmaster_i;
         end
         if (ei_i || iret_i) master_q <= 1'b1;
         // disabling sources take precedence over every setter
         if (di_i || ack_i)  master_q <= 1'b0;
      end
   end

   assign mask_o   = mask_q;
   assign master_o = master_q;

endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb #(
   parameter int N  = 6,
   parameter int LW = 3
) (
   input  logic [N-1:0]  pend_i,
   input  logic [N-1:0]  mask_i,
   input  logic          master_i,
   output logic          req_o,
   output logic [LW-1:0] lvl_o
);

   logic [N-1:0] elig;

   always_comb begin
      elig  = pend_i & mask_i & {N{master_i}};
      req_o = |elig;
      lvl_o = '0;
      // scan from least urgent so the lowest index is written last
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i]) lvl_o = LW'(i);
      end
   end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
   parameter int          NUM_LVL  = 6,
   parameter int          DATA_W   = 8,
   parameter int          ADDR_W   = 8,
   parameter logic [7:0]  REQ_ADDR = 8'hFA,
   parameter logic [7:0]  MSK_ADDR = 8'hFB,
   parameter int          LVL_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] irq_in,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               ei_stb,
   input  logic               di_stb,
   input  logic               iret_stb,
   input  logic               ack_stb,
   output logic               int_req,
   output logic [LVL_W-1:0]   int_lvl
);
   import lvl_irq_pkg::*;

   localparam int GAP_W  = DATA_W - 1 - NUM_LVL;
   localparam int MIN_LW = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;

   if (NUM_LVL < 2 || GAP_W < 1) begin : g_bad_lvl
      $error("NUM_LVL must be at least 2 and leave a spare bit below the master enable");
   end
   if (LVL_W < MIN_LW) begin : g_bad_lw
      $error("LVL_W too narrow for NUM_LVL");
   end
   if (ADDR_W < 8 && (REQ_ADDR >> ADDR_W) != 0) begin : g_bad_addr
      $error("register addresses do not fit ADDR_W");
   end
   if (REQ_ADDR == MSK_ADDR) begin : g_bad_map
      $error("request and mask addresses must differ");
   end

   reg_sel_e           sel;
   logic               req_wr;
   logic               msk_wr;
   logic [NUM_LVL-1:0] rise_w;
   logic [NUM_LVL-1:0] pend_q;
   logic [NUM_LVL-1:0] mask_q;
   logic               master_q;
   logic               armed_q;
   logic [GAP_W-1:0]   unused_wbits;

   always_comb begin
      if (reg_addr == ADDR_W'(REQ_ADDR))      sel = SEL_REQ;
      else if (reg_addr == ADDR_W'(MSK_ADDR)) sel = SEL_MSK;
      else                                    sel = SEL_NONE;
   end

   assign req_wr       = reg_wr && (sel == SEL_REQ);
   assign msk_wr       = reg_wr && (sel == SEL_MSK);
   assign unused_wbits = reg_wdata[DATA_W-2:NUM_LVL];

   lvl_irq_edge #(.N(NUM_LVL)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (irq_in),
      .rise_o  (rise_w)
   );

   lvl_irq_pend #(.N(NUM_LVL), .LW(LVL_W)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (ei_stb),
      .wr_i      (req_wr),
      .wdata_i   (reg_wdata[NUM_LVL-1:0]),
      .rise_i    (rise_w),
      .ack_i     (ack_stb),
      .ack_vld_i (int_req),
      .ack_lvl_i (int_lvl),
      .pend_o    (pend_q),
      .armed_o   (armed_q)
   );

   lvl_irq_mask #(.N(NUM_LVL)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (msk_wr),
      .wdata_i   (reg_wdata[NUM_LVL-1:0]),
      .wmaster_i (reg_wdata[DATA_W-1]),
      .ei_i      (ei_stb),
      .di_i      (di_stb),
      .iret_i    (iret_stb),
      .ack_i     (ack_stb),
      .mask_o    (mask_q),
      .master_o  (master_q)
   );

   lvl_irq_arb #(.N(NUM_LVL), .LW(LVL_W)) u_arb (
      .pend_i   (pend_q),
      .mask_i   (mask_q),
      .master_i (master_q),
      .req_o    (int_req),
      .lvl_o    (int_lvl)
   );

   always_comb begin
      unique case (sel)
         SEL_REQ: reg_rdata = {{(DATA_W-NUM_LVL){1'b0}}, pend_q};
         SEL_MSK: reg_rdata = {master_q, {GAP_W{1'b0}}, mask_q};
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
   parameter int         N       = 6,
   parameter int         LW      = 3,
   parameter int         DW      = 8,
   parameter int         AW      = 8,
   parameter logic [7:0] MSK_A   = 8'hFB
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] reg_addr,
   input logic [DW-1:0] reg_rdata,
   input logic          req_wr,
   input logic          ei_stb,
   input logic          di_stb,
   input logic          iret_stb,
   input logic          ack_stb,
   input logic          int_req,
   input logic [LW-1:0] int_lvl,
   input logic [N-1:0]  rise_w,
   input logic [N-1:0]  pend_q,
   input logic [N-1:0]  mask_q,
   input logic          master_q,
   input logic          armed_q
);

   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   assert_hold_until_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> pend_q == '0);

   for (genvar i = 0; i < N; i++) begin : g_lvl
      assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_q && rise_w[i]) |=> pend_q[i]);
   end

   assert_gap_bit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == AW'(MSK_A)) |-> !reg_rdata[DW-2]);

   assert_winner_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (master_q && pend_q[int_lvl] && mask_q[int_lvl]));

   assert_no_better_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> ((pend_q & mask_q & ((ONE << int_lvl) - ONE)) == '0));

   assert_idle_when_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (master_q && (pend_q & mask_q) != '0) |-> int_req);

   assert_di_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      di_stb |=> !master_q);

   assert_ei_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_stb && !di_stb && !ack_stb) |=> master_q);

   assert_ack_drops_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> !master_q);

   assert_ack_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && int_req && !req_wr && rise_w == '0) |=> !pend_q[$past(int_lvl)]);

   assert_iret_rearms_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iret_stb && !di_stb && !ack_stb) |=> master_q);

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(
   .N     (NUM_LVL),
   .LW    (LVL_W),
   .DW    (DATA_W),
   .AW    (ADDR_W),
   .MSK_A (MSK_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .req_wr    (req_wr),
   .ei_stb    (ei_stb),
   .di_stb    (di_stb),
   .iret_stb  (iret_stb),
   .ack_stb   (ack_stb),
   .int_req   (int_req),
   .int_lvl   (int_lvl),
   .rise_w    (rise_w),
   .pend_q    (pend_q),
   .mask_q    (mask_q),
   .master_q  (master_q),
   .armed_q   (armed_q)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;

   localparam logic [7:0] A_REQ = 8'hFA;
   localparam logic [7:0] A_MSK = 8'hFB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] irq_in = '0;
   logic [7:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ei_stb = 1'b0;
   logic       di_stb = 1'b0;
   logic       iret_stb = 1'b0;
   logic       ack_stb = 1'b0;
   logic       int_req;
   logic [2:0] int_lvl;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   lvl_irq_ctrl u_lvl_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ei_stb    (ei_stb),
      .di_stb    (di_stb),
      .iret_stb  (iret_stb),
      .ack_stb   (ack_stb),
      .int_req   (int_req),
      .int_lvl   (int_lvl)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // advance one edge; inputs change and outputs are sampled 1 ns after it
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic chk_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(tag, 32'(d), 32'(exp));
   endtask

   task automatic chk_out(input string tag, input logic req, input logic [2:0] lvl);
      chk({tag, " int_req"}, 32'(int_req), 32'(req));
      if (req) chk({tag, " int_lvl"}, 32'(int_lvl), 32'(lvl));
   endtask

   task automatic t_reset();
      chk_reg("R1 request after reset", A_REQ, 8'h00);
      chk_reg("R1 mask after reset", A_MSK, 8'h00);
      chk("R1 int_req after reset", 32'(int_req), 32'd0);
   endtask

   task automatic t_unarmed();
      irq_in[2] = 1'b1;
      tick();
      irq_in[2] = 1'b0;
      tick();
      chk_reg("R2 edge before arming ignored", A_REQ, 8'h00);
      wr(A_REQ, 8'h3F);
      chk_reg("R2 write before arming ignored", A_REQ, 8'h00);
      // edge in the arming cycle is also dropped
      ei_stb = 1'b1; irq_in[1] = 1'b1;
      tick();
      ei_stb = 1'b0; irq_in[1] = 1'b0;
      tick();
      chk_reg("R2 edge in arming cycle ignored", A_REQ, 8'h00);
      chk_reg("R7 master set by ei", A_MSK, 8'h80);
      wr(A_MSK, 8'h00);
   endtask

   task automatic t_edges();
      irq_in[3] = 1'b1;
      tick();
      chk_reg("R3 rising edge sets bit", A_REQ, 8'h08);
      wr(A_REQ, 8'h00);
      repeat (3) tick();
      chk_reg("R3 held line does not refire", A_REQ, 8'h00);
      irq_in[3] = 1'b0;
      irq_in[5] = 1'b1;
      tick();
      irq_in[5] = 1'b0;
      chk_reg("R3 second level edge", A_REQ, 8'h20);
      wr(A_REQ, 8'h00);
   endtask

   task automatic t_soft();
      wr(A_MSK, 8'hFF);
      chk_reg("R5 gap bit reads zero", A_MSK, 8'hBF);
      wr(A_REQ, 8'hFF);
      chk_reg("R5 top request bits read zero", A_REQ, 8'h3F);
      chk_out("R6 all pending picks level 0", 1'b1, 3'd0);
      wr(A_REQ, 8'h20);
      chk_out("R4 software request level 5", 1'b1, 3'd5);
      wr(A_REQ, 8'h24);
      chk_out("R6 level 2 beats level 5", 1'b1, 3'd2);
      wr(A_MSK, 8'hBB);
      chk_out("R6 masked level 2 skipped", 1'b1, 3'd5);
      wr(A_MSK, 8'h3F);
      chk_out("R6 no request without master", 1'b0, 3'd0);
      // software clear collides with a hardware edge on level 1
      reg_addr = A_REQ; reg_wdata = 8'h00; reg_wr = 1'b1; irq_in[1] = 1'b1;
      tick();
      reg_wr = 1'b0; irq_in[1] = 1'b0;
      chk_reg("R4 edge survives same-cycle clear", A_REQ, 8'h02);
      wr(A_REQ, 8'h00);
   endtask

   task automatic t_master();
      wr(A_MSK, 8'h3F);
      wr(A_REQ, 8'h01);
      chk_out("R7 disabled before ei", 1'b0, 3'd0);
      ei_stb = 1'b1; tick(); ei_stb = 1'b0;
      chk_out("R7 ei presents level 0", 1'b1, 3'd0);
      chk_reg("R7 mask reads master", A_MSK, 8'hBF);
      di_stb = 1'b1; tick(); di_stb = 1'b0;
      chk_out("R7 di removes request", 1'b0, 3'd0);
      ei_stb = 1'b1; di_stb = 1'b1; tick(); ei_stb = 1'b0; di_stb = 1'b0;
      chk_reg("R7 di wins over ei", A_MSK, 8'h3F);
      wr(A_REQ, 8'h00);
   endtask

   task automatic t_ack();
      wr(A_MSK, 8'hBF);
      wr(A_REQ, 8'h11);
      chk_out("R8 level 0 before ack", 1'b1, 3'd0);
      ack_stb = 1'b1; tick(); ack_stb = 1'b0;
      chk_reg("R8 ack retires level 0", A_REQ, 8'h10);
      chk_reg("R8 ack clears master", A_MSK, 8'h3F);
      chk_out("R8 idle after ack", 1'b0, 3'd0);
      iret_stb = 1'b1; tick(); iret_stb = 1'b0;
      chk_out("R9 iret presents level 4", 1'b1, 3'd4);
      chk_reg("R9 iret restores master", A_MSK, 8'hBF);
      // acknowledge level 4 while its line rises again
      ack_stb = 1'b1; irq_in[4] = 1'b1; tick(); ack_stb = 1'b0; irq_in[4] = 1'b0;
      chk_reg("R8 new edge wins over ack clear", A_REQ, 8'h10);
      chk_reg("R8 master off after second ack", A_MSK, 8'h3F);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_unarmed();
      t_edges();
      t_soft();
      t_master();
      t_ack();
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

endmodule